// File: doc/BRIEF.md
# Secure Program Memory Access Controller

This block models the programming and read-back port of a small on-chip code memory. A mode input selects one of five operations: write a code byte, write a byte of the scrambling key, set a lock bit, read a code byte back, or read a fixed identification byte. A byte is committed only after the active-low program strobe has pulsed a fixed number of times with the operation held steady. Each commit is reported by a one-cycle done pulse, and each refused commit by a one-cycle error pulse.

The read-back path scrambles every code byte. It takes the XNOR of the byte with a key byte chosen by the low address bits. The key table cannot be read through any mode. Three lock bits take effect in stages. Any one of them freezes code and key writes. The first also flags that external table fetches are blocked and holds the external-fetch select level. Bits one and two together blank read-back. All three together flag that external execution is disabled. Reset returns the part to its blank state: code, key and lock bits all in their unprogrammed form.

Top module: `secure_code_port`

## Requirements
- R1: A write commits only on the falling strobe edge that completes STROBES (default 5) low pulses with mode, address and data unchanged. `wr_done` is high for exactly the one cycle after that edge, and earlier pulses raise nothing.
- R2: Any change of mode, address or data while a pulse count is open discards the count. A fresh run of STROBES pulses is then needed.
- R3: After reset the key table is all ones, so read-back (mode 4) returns the plain code byte. Unwritten code bytes read FFH.
- R4: In mode 4, `rdata` equals code[addr] XNOR key[addr[5:0]]. It is registered and valid one cycle after mode and address are applied.
- R5: The key table is never visible. In every mode other than 4 and 5, `rdata` is FFH.
- R6: With any lock bit set, commits in mode 1 (code) and mode 2 (key) leave memory unchanged and raise `wr_err` for one cycle instead of `wr_done`. Lock bits that are still clear remain settable.
- R7: With lock bits 1 and 2 both set, `verify_block` is high and mode 4 returns FFH.
- R8: With all three lock bits set, `exec_block` is high.
- R9: With lock bit 1 set, `fetch_block` is high and `ext_sel_held` keeps the `ext_sel` level sampled in the first cycle after reset. Before that, `ext_sel_held` follows `ext_sel`.
- R10: Mode 5 returns 15H at address 30H, 99H at 31H, 02H at 60H and FFH elsewhere.
- R11: In mode 3, address 1, 2 or 3 selects lock bit 1, 2 or 3. A commit to any other address raises `wr_err` and sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | 0 idle, 1 code write, 2 key write, 3 lock write, 4 read-back, 5 identification |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Byte to write |
| prog_n | input | 1 | Active-low program strobe |
| ext_sel | input | 1 | External fetch select level |
| rdata | output | 8 | Registered read byte |
| wr_done | output | 1 | One-cycle pulse on an accepted commit |
| wr_err | output | 1 | One-cycle pulse on a refused commit |
| fetch_block | output | 1 | External table fetch blocked |
| verify_block | output | 1 | Read-back disabled |
| exec_block | output | 1 | External execution disabled |
| ext_sel_held | output | 1 | Effective external fetch select level |

## Verification
Every result comes from a register one clock edge away from the stimulus that causes it. `rdata` reflects the mode and address present at the previous rising edge. `wr_done`, `wr_err` and the lock flags change at the edge that samples the final low strobe. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check lands half a cycle after the edge that produced the value. The bench also records both pulse outputs after every strobe, so that a commit arriving too early is caught as well as one that never arrives.

// File: rtl/secure_code_port.sv
module secure_code_port #(
  parameter int ADDR_W    = 8,
  parameter int KEY_DEPTH = 64,
  parameter int STROBES   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              prog_n,
  input  logic              ext_sel,
  output logic [7:0]        rdata,
  output logic              wr_done,
  output logic              wr_err,
  output logic              fetch_block,
  output logic              verify_block,
  output logic              exec_block,
  output logic              ext_sel_held
);
  localparam int CODE_DEPTH = 1 << ADDR_W;
  localparam int KEY_W      = $clog2(KEY_DEPTH);
  localparam int CNT_W      = $clog2(STROBES + 1);
  localparam logic [2:0] M_PCODE = 3'd1, M_PKEY = 3'd2, M_PSEC = 3'd3,
                         M_READ  = 3'd4, M_SIG  = 3'd5;

  logic [7:0]        code_mem [CODE_DEPTH];
  logic [7:0]        key_mem  [KEY_DEPTH];
  logic [2:0]        sec_q;
  logic              prog_q, armed_q, ea_q;
  logic [CNT_W-1:0]  cnt_q, cnt_eff;
  logic [2:0]        cap_mode;
  logic [ADDR_W-1:0] cap_addr;
  logic [7:0]        cap_data;
  logic [7:0]        rd_next, sig_byte;

  wire is_prog  = (mode == M_PCODE) || (mode == M_PKEY) || (mode == M_PSEC);
  wire fall     = prog_q & ~prog_n;
  wire same     = {mode, addr, wdata} == {cap_mode, cap_addr, cap_data};
  assign cnt_eff = (cnt_q != '0 && !same) ? '0 : cnt_q;
  wire last     = fall && is_prog && (cnt_eff == CNT_W'(STROBES - 1));
  wire mem_cmd  = (mode == M_PCODE) || (mode == M_PKEY);
  wire sec_ok   = (addr[ADDR_W-1:2] == '0) && (addr[1:0] != 2'b00);
  wire accept   = last && (mem_cmd ? (sec_q == 3'b000) : sec_ok);
  wire [1:0] sec_idx = addr[1:0] - 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q   <= 1'b1;
      cnt_q    <= '0;
      cap_mode <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      prog_q <= prog_n;
      if (fall && is_prog) begin
        cnt_q    <= last ? '0 : cnt_eff + CNT_W'(1);
        cap_mode <= mode;
        cap_addr <= addr;
        cap_data <= wdata;
      end else begin
        cnt_q <= cnt_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
      for (int i = 0; i < KEY_DEPTH; i++)  key_mem[i]  <= 8'hFF;
      sec_q   <= 3'b000;
      wr_done <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      wr_done <= accept;
      wr_err  <= last && !accept;
      if (accept) begin
        case (mode)
          M_PCODE: code_mem[addr]              <= wdata;
          M_PKEY:  key_mem[addr[KEY_W-1:0]]    <= wdata;
          default: sec_q[sec_idx]              <= 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      ea_q    <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      ea_q    <= ext_sel;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(8'h30))      sig_byte = 8'h15;
    else if (addr == ADDR_W'(8'h31)) sig_byte = 8'h99;
    else if (addr == ADDR_W'(8'h60)) sig_byte = 8'h02;
    else                             sig_byte = 8'hFF;
    case (mode)
      M_READ:  rd_next = verify_block ? 8'hFF
                       : (code_mem[addr] ~^ key_mem[addr[KEY_W-1:0]]);
      M_SIG:   rd_next = sig_byte;
      default: rd_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'hFF;
    else        rdata <= rd_next;
  end

  assign fetch_block  = sec_q[0];
  assign verify_block = sec_q[0] & sec_q[1];
  assign exec_block   = &sec_q;
  assign ext_sel_held = sec_q[0] ? ea_q : ext_sel;

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done && !wr_err);
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> !wr_err && !wr_done);
  p_mem_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && mem_cmd && sec_q != 3'b000) |=> wr_err && !wr_done);
  p_sec_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q != 3'b000) |=> (sec_q != 3'b000));
  p_read_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ && verify_block) |=> rdata == 8'hFF);
  p_exec_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_block |-> verify_block && fetch_block);
  p_ea_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_block |=> $stable(ext_sel_held));
  p_key_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_READ && mode != M_SIG) |=> rdata == 8'hFF);
endmodule

// File: tb/secure_code_port_tb.sv
module secure_code_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       prog_n = 1'b1;
  logic       ext_sel = 1'b1;
  logic [7:0] rdata;
  logic wr_done, wr_err, fetch_block, verify_block, exec_block, ext_sel_held;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  secure_code_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wdata(wdata),
    .prog_n(prog_n), .ext_sel(ext_sel), .rdata(rdata), .wr_done(wr_done),
    .wr_err(wr_err), .fetch_block(fetch_block), .verify_block(verify_block),
    .exec_block(exec_block), .ext_sel_held(ext_sel_held)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    mode = m; addr = a; wdata = d;
  endtask

  task automatic strobes(input int n, output int dones, output int errs,
                         output logic last_done, output logic last_err);
    dones = 0; errs = 0; last_done = 0; last_err = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) prog_n = 1'b0;
      @(negedge clk);
      last_done = wr_done; last_err = wr_err;
      dones += int'(wr_done); errs += int'(wr_err);
      prog_n = 1'b1;
    end
  endtask

  task automatic read(input logic [2:0] m, input logic [7:0] a, output logic [7:0] v);
    setup(m, a, 8'h00);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic t_reset;
    check("R3 reset rdata", rdata, 8'hFF);
    check("R8 reset flags", {4'b0, fetch_block, verify_block, exec_block, wr_done}, 8'h00);
  endtask

  task automatic t_five_pulse;
    int d, e; logic ld, le; logic [7:0] v;
    read(3'd4, 8'h12, v);
    check("R3 blank code", v, 8'hFF);
    setup(3'd1, 8'h12, 8'h5A);
    strobes(4, d, e, ld, le);
    check("R1 no early done", 8'(d + e), 8'd0);
    strobes(1, d, e, ld, le);
    check("R1 fifth done", {7'b0, ld}, 8'd1);
    @(negedge clk);
    check("R1 done one cycle", {7'b0, wr_done}, 8'd0);
    read(3'd4, 8'h12, v);
    check("R3 plain readback", v, 8'h5A);
  endtask

  task automatic t_abort;
    int d, e; logic ld, le; logic [7:0] v;
    setup(3'd1, 8'h20, 8'h11);
    strobes(3, d, e, ld, le);
    setup(3'd1, 8'h20, 8'h22);
    strobes(4, d, e, ld, le);
    check("R2 restart count", 8'(d + e), 8'd0);
    strobes(1, d, e, ld, le);
    check("R2 commit after restart", {7'b0, ld}, 8'd1);
    read(3'd4, 8'h20, v);
    check("R2 new data", v, 8'h22);
  endtask

  task automatic t_key;
    int d, e; logic ld, le; logic [7:0] v;
    setup(3'd2, 8'h12, 8'h0F);
    strobes(5, d, e, ld, le);
    check("R4 key commit", {7'b0, ld}, 8'd1);
    setup(3'd1, 8'h52, 8'h33);
    strobes(5, d, e, ld, le);
    read(3'd4, 8'h12, v);
    check("R4 xnor 12", v, 8'hAA);
    read(3'd4, 8'h52, v);
    check("R4 alias low bits", v, 8'hC3);
    read(3'd4, 8'h20, v);
    check("R4 other key blank", v, 8'h22);
    read(3'd2, 8'h12, v);
    check("R5 key hidden", v, 8'hFF);
    read(3'd5, 8'h12, v);
    check("R5 sig mode no key", v, 8'hFF);
  endtask

  task automatic t_sig;
    logic [7:0] v;
    read(3'd5, 8'h30, v); check("R10 sig 30", v, 8'h15);
    read(3'd5, 8'h31, v); check("R10 sig 31", v, 8'h99);
    read(3'd5, 8'h60, v); check("R10 sig 60", v, 8'h02);
    read(3'd5, 8'h61, v); check("R10 sig other", v, 8'hFF);
  endtask

  task automatic t_lock;
    int d, e; logic ld, le; logic [7:0] v;
    setup(3'd3, 8'h00, 8'h00);
    strobes(5, d, e, ld, le);
    check("R11 bad index err", {6'b0, ld, le}, 8'h01);
    check("R11 nothing set", {7'b0, fetch_block}, 8'd0);
    ext_sel = 1'b0;
    @(negedge clk);
    check("R9 follows before lock", {7'b0, ext_sel_held}, 8'd0);
    ext_sel = 1'b1;
    setup(3'd3, 8'h01, 8'h00);
    strobes(5, d, e, ld, le);
    check("R9 fetch_block", {6'b0, fetch_block, verify_block}, 8'h02);
    ext_sel = 1'b0;
    @(negedge clk);
    check("R9 ea held", {7'b0, ext_sel_held}, 8'd1);
    setup(3'd1, 8'h12, 8'h00);
    strobes(5, d, e, ld, le);
    check("R6 code write refused", {6'b0, ld, le}, 8'h01);
    setup(3'd2, 8'h12, 8'hF0);
    strobes(5, d, e, ld, le);
    check("R6 key write refused", {6'b0, ld, le}, 8'h01);
    read(3'd4, 8'h12, v);
    check("R6 memory unchanged", v, 8'hAA);
    setup(3'd3, 8'h02, 8'h00);
    strobes(5, d, e, ld, le);
    check("R6 next lock settable", {6'b0, ld, le}, 8'h02);
    check("R7 verify_block", {6'b0, verify_block, exec_block}, 8'h02);
    read(3'd4, 8'h12, v);
    check("R7 readback blank", v, 8'hFF);
    setup(3'd3, 8'h03, 8'h00);
    strobes(5, d, e, ld, le);
    check("R8 exec_block", {7'b0, exec_block}, 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_five_pulse();
    t_abort();
    t_key();
    t_sig();
    t_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule